// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside bus master borrow the external memory bus through an active-low hold/acknowledge handshake. The master pulls a hold pin low; once the internal bus controller reaches a cycle boundary, the block tells the controller to float the bus and pulls an acknowledge pin low. If the internal controller wants the bus back while it is lent out, the block pulls an active-low bus request pin low toward the outside master. When the master lets the hold pin go high again, the acknowledge clears and the controller takes the bus back.

Three shared port pins carry these signals. While a protocol enable input is low, those pins behave as plain port pins: each one's output enable and output value come from a small configuration register. While the enable is high, the pins are taken over for the handshake, and writes to their configuration are dropped. The hold pin is asynchronous to the block clock and passes through a synchronizer before use.

Top module: `bus_hold_arb`

## Requirements
- R1: After a synchronous reset, `bus_release_o` is 0, and the stored pin configuration is all zero. With `hold_en` low, `pad_oe_o` and `pad_o` are therefore 3'b000.
- R2: Pin positions are bit 0 for bus request, bit 1 for hold input and bit 2 for acknowledge. With `hold_en` high and `cyc_busy` low, a low level on `pad_i[1]` that is present before rising edge k makes `bus_release_o` read 1 after rising edge k+2, because the input passes through two synchronizer flops.
- R3: A hold request is granted only while `cyc_busy` is low. While `cyc_busy` stays high, `bus_release_o` stays 0 whatever the hold pin does. The grant takes effect at the first rising edge where the synchronized request is active and `cyc_busy` is low.
- R4: With `hold_en` high, `pad_o[2]` (acknowledge) is the inverse of `bus_release_o`. It is low exactly while the bus is released.
- R5: With `hold_en` high, `pad_o[0]` (bus request) is low after a rising edge exactly when that edge leaves the bus released and `cyc_pending` was high at that edge. Otherwise `pad_o[0]` is high.
- R6: When `pad_i[1]` goes high before rising edge k, `bus_release_o` returns to 0 after rising edge k+2.
- R7: With `hold_en` high, `pad_oe_o` is 3'b101. The hold pin is an input driven with output value 0; the request and acknowledge pins are outputs.
- R8: A configuration write (`cfg_we` high at a rising edge) stores `cfg_dir` and `cfg_dat` only when `hold_en` is low. A write made while `hold_en` is high has no effect, so once the enable is cleared the pins show the configuration stored earlier.
- R9: With `hold_en` low, `pad_oe_o` equals the stored direction bits and `pad_o` equals the stored data bits. The hold pin is ignored: after any rising edge with `hold_en` low, `bus_release_o` is 0. This includes clearing the enable while the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_en | input | 1 | Hold protocol enable |
| pad_i | input | 3 | Pin input levels; bit 1 is the asynchronous hold request, active low |
| pad_o | output | 3 | Pin output values |
| pad_oe_o | output | 3 | Pin output enables, 1 = drive |
| cfg_we | input | 1 | Pin configuration write strobe |
| cfg_dir | input | 3 | Direction bits to store, 1 = output |
| cfg_dat | input | 3 | Output data bits to store |
| cyc_busy | input | 1 | Internal bus cycle in progress; low marks a cycle boundary |
| cyc_pending | input | 1 | Internal controller has an external cycle waiting |
| bus_release_o | output | 1 | Tells the bus controller to float the external bus |

## Verification
A wrong arbitration state appears as a stuck or early release. `bus_release_o` and the acknowledge pin would disagree with the hold pin level delayed by exactly two edges, which is visible on the third edge after the hold pin changes. A grant slipped into the middle of a busy cycle shows up at the first edge where `cyc_busy` is high. A corrupted pin configuration is hidden while the protocol is on. It appears on `pad_oe_o` and `pad_o` at the half cycle after the enable drops, so the bench compares the pins every cycle across enable toggles.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  localparam int PIN_W    = 3;
  localparam int REQ_PIN  = 0;
  localparam int HOLD_PIN = 1;
  localparam int ACK_PIN  = 2;

  typedef enum logic {
    ARB_OWN      = 1'b0,
    ARB_RELEASED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RESET_VAL;
        else     chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic hold_sync_n,
  input  logic cyc_busy,
  input  logic cyc_pending,
  output logic release_o,
  output logic breq_o
);
  arb_state_e state_q, state_d;
  logic       breq_q;
  logic       want_hold;

  assign want_hold = enable & ~hold_sync_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_OWN:      if (want_hold && !cyc_busy) state_d = ARB_RELEASED;
      ARB_RELEASED: if (!want_hold)             state_d = ARB_OWN;
      default:                                  state_d = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_OWN;
      breq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      breq_q  <= (state_d == ARB_RELEASED) && cyc_pending;
    end
  end

  assign release_o = (state_q == ARB_RELEASED);
  assign breq_o    = breq_q;

  // R3: a grant only ever lands at a cycle boundary
  p_grant_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> !$past(cyc_busy));
  // R9: protocol off means no release after the next edge
  p_off_no_release_r9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !release_o);
  // R6: released and the synchronized hold is gone -> bus returns
  p_return_r6: assert property (@(posedge clk) disable iff (rst)
    (release_o && hold_sync_n) |=> !release_o);
  // R5: a bus request is only raised while released
  p_breq_only_released_r5: assert property (@(posedge clk) disable iff (rst)
    breq_o |-> release_o);
endmodule

// File: rtl/hold_pin_cfg.sv
module hold_pin_cfg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lock,
  input  logic         wr_en,
  input  logic [W-1:0] wr_dir,
  input  logic [W-1:0] wr_dat,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] dat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_o <= '0;
      dat_o <= '0;
    end else if (wr_en && !lock) begin
      dir_o <= wr_dir;
      dat_o <= wr_dat;
    end
  end

  // R8: writes are dropped while the protocol owns the pins
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(dir_o) && $stable(dat_o)));
endmodule

// File: rtl/hold_pin_mux.sv
module hold_pin_mux
  import hold_arb_pkg::*;
(
  input  logic             enable,
  input  logic [PIN_W-1:0] cfg_dir,
  input  logic [PIN_W-1:0] cfg_dat,
  input  logic             release_i,
  input  logic             breq_i,
  output logic [PIN_W-1:0] pad_o,
  output logic [PIN_W-1:0] pad_oe_o
);
  logic [PIN_W-1:0] fn_val;
  logic [PIN_W-1:0] fn_oe;

  genvar i;
  generate
    for (i = 0; i < PIN_W; i++) begin : g_pin
      if (i == REQ_PIN) begin : g_req
        assign fn_val[i] = ~breq_i;
        assign fn_oe[i]  = 1'b1;
      end else if (i == ACK_PIN) begin : g_ack
        assign fn_val[i] = ~release_i;
        assign fn_oe[i]  = 1'b1;
      end else begin : g_in
        assign fn_val[i] = 1'b0;
        assign fn_oe[i]  = 1'b0;
      end
      assign pad_o[i]    = enable ? fn_val[i] : cfg_dat[i];
      assign pad_oe_o[i] = enable ? fn_oe[i]  : cfg_dir[i];
    end
  endgenerate
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import hold_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_en,
  input  logic [PIN_W-1:0] pad_i,
  output logic [PIN_W-1:0] pad_o,
  output logic [PIN_W-1:0] pad_oe_o,
  input  logic             cfg_we,
  input  logic [PIN_W-1:0] cfg_dir,
  input  logic [PIN_W-1:0] cfg_dat,
  input  logic             cyc_busy,
  input  logic             cyc_pending,
  output logic             bus_release_o
);
  logic             hold_sync_n;
  logic             breq;
  logic [PIN_W-1:0] st_dir, st_dat;

  hold_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_i(pad_i[HOLD_PIN]), .sync_o(hold_sync_n)
  );

  hold_arb_fsm u_fsm (
    .clk(clk), .rst(rst), .enable(hold_en), .hold_sync_n(hold_sync_n),
    .cyc_busy(cyc_busy), .cyc_pending(cyc_pending),
    .release_o(bus_release_o), .breq_o(breq)
  );

  hold_pin_cfg #(.W(PIN_W)) u_cfg (
    .clk(clk), .rst(rst), .lock(hold_en), .wr_en(cfg_we),
    .wr_dir(cfg_dir), .wr_dat(cfg_dat), .dir_o(st_dir), .dat_o(st_dat)
  );

  hold_pin_mux u_mux (
    .enable(hold_en), .cfg_dir(st_dir), .cfg_dat(st_dat),
    .release_i(bus_release_o), .breq_i(breq),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o)
  );

  // R7: pins are forced to their handshake directions while enabled
  p_pins_forced_r7: assert property (@(posedge clk) disable iff (rst)
    hold_en |-> (pad_oe_o == 3'b101));
  // R4: acknowledge pin tracks the release toward the controller
  p_ack_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    hold_en |-> (pad_o[ACK_PIN] == !bus_release_o));
endmodule

// File: tb/sim_bus_hold_arb.sv
`timescale 1ns/1ps
module sim_bus_hold_arb;
  localparam realtime HALF = 10.0;

  logic       clk = 1'b0;
  logic       rst;
  logic       hold_en;
  logic [2:0] pad_i;
  logic [2:0] pad_o, pad_oe_o;
  logic       cfg_we;
  logic [2:0] cfg_dir, cfg_dat;
  logic       cyc_busy, cyc_pending;
  logic       bus_release_o;

  int checks = 0;
  int fails  = 0;

  // bench reference state, updated from the requirements
  logic       m_s1, m_s2, m_held, m_breq;
  logic [2:0] m_dir, m_dat;

  always #(HALF) clk = ~clk;

  bus_hold_arb u0 (
    .clk(clk), .rst(rst), .hold_en(hold_en), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe_o(pad_oe_o), .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_dat(cfg_dat),
    .cyc_busy(cyc_busy), .cyc_pending(cyc_pending), .bus_release_o(bus_release_o)
  );

  function automatic logic ref_next_held(logic held, logic en, logic s2, logic busy);
    logic want;
    want = en & ~s2;
    return held ? want : (want & ~busy);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_held <= 1'b0; m_breq <= 1'b0;
      m_dir <= '0; m_dat <= '0;
    end else begin
      m_s1 <= pad_i[1];
      m_s2 <= m_s1;
      m_held <= ref_next_held(m_held, hold_en, m_s2, cyc_busy);
      m_breq <= ref_next_held(m_held, hold_en, m_s2, cyc_busy) & cyc_pending;
      if (cfg_we && !hold_en) begin
        m_dir <= cfg_dir; m_dat <= cfg_dat;
      end
    end
  end

  function automatic logic [2:0] exp_oe();
    return hold_en ? 3'b101 : m_dir;
  endfunction
  function automatic logic [2:0] exp_pad();
    return hold_en ? {~m_held, 1'b0, ~m_breq} : m_dat;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cmp_all(string req);
    check(req, {7'd0, bus_release_o}, {7'd0, m_held});
    check(req, {5'd0, pad_oe_o}, {5'd0, exp_oe()});
    check(req, {5'd0, pad_o}, {5'd0, exp_pad()});
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; hold_en = 1'b0; pad_i = 3'b111; cfg_we = 1'b0;
    cfg_dir = '0; cfg_dat = '0; cyc_busy = 1'b0; cyc_pending = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check("R1 release", {7'd0, bus_release_o}, 8'd0);
    check("R1 oe", {5'd0, pad_oe_o}, 8'd0);
    check("R1 pad", {5'd0, pad_o}, 8'd0);

    // R9: config visible when off, hold ignored
    cfg_we = 1'b1; cfg_dir = 3'b110; cfg_dat = 3'b011;
    tick(); cfg_we = 1'b0;
    check("R9 oe", {5'd0, pad_oe_o}, 8'h06);
    check("R9 pad", {5'd0, pad_o}, 8'h03);
    pad_i[1] = 1'b0;
    repeat (4) tick();
    check("R9 hold ignored", {7'd0, bus_release_o}, 8'd0);
    pad_i[1] = 1'b1;
    repeat (3) tick();

    // R7: takeover
    hold_en = 1'b1;
    #1;
    check("R7 oe", {5'd0, pad_oe_o}, 8'h05);
    check("R7 pad", {5'd0, pad_o}, 8'h05);

    // R8: write ignored while enabled
    cfg_we = 1'b1; cfg_dir = 3'b001; cfg_dat = 3'b100;
    tick(); cfg_we = 1'b0;

    // R2: grant latency, hold low before edge k -> release after k+2
    pad_i[1] = 1'b0;
    tick(); check("R2 edge k", {7'd0, bus_release_o}, 8'd0);
    tick(); check("R2 edge k+1", {7'd0, bus_release_o}, 8'd0);
    tick(); check("R2 edge k+2", {7'd0, bus_release_o}, 8'd1);
    check("R4 ack low", {7'd0, pad_o[2]}, 8'd0);

    // R5: bus request one edge after pending
    check("R5 idle", {7'd0, pad_o[0]}, 8'd1);
    cyc_pending = 1'b1;
    tick(); check("R5 asserted", {7'd0, pad_o[0]}, 8'd0);
    cyc_pending = 1'b0;
    tick(); check("R5 cleared", {7'd0, pad_o[0]}, 8'd1);

    // R6: return latency
    pad_i[1] = 1'b1;
    tick(); tick(); check("R6 edge k+1", {7'd0, bus_release_o}, 8'd1);
    tick(); check("R6 edge k+2", {7'd0, bus_release_o}, 8'd0);
    check("R4 ack high", {7'd0, pad_o[2]}, 8'd1);

    // R3: busy blocks grant
    cyc_busy = 1'b1; pad_i[1] = 1'b0;
    repeat (6) tick();
    check("R3 blocked", {7'd0, bus_release_o}, 8'd0);
    cyc_busy = 1'b0;
    tick(); check("R3 granted at boundary", {7'd0, bus_release_o}, 8'd1);

    // R9: clearing the enable while released drops release next edge
    hold_en = 1'b0;
    tick(); check("R9 drop on disable", {7'd0, bus_release_o}, 8'd0);
    // R8: earlier config survived the ignored write
    check("R8 dir kept", {5'd0, pad_oe_o}, 8'h06);
    check("R8 dat kept", {5'd0, pad_o}, 8'h03);
    pad_i[1] = 1'b1;
    repeat (3) tick();

    // random phase against reference
    void'($urandom(32'd1977));
    for (int n = 0; n < 3000; n++) begin
      cmp_all("R2-R9 random");
      if (($urandom % 16) == 0) hold_en = ~hold_en;
      if (($urandom % 6) == 0)  pad_i[1] = ~pad_i[1];
      pad_i[0] = 1'($urandom); pad_i[2] = 1'($urandom);
      cyc_busy    = (($urandom % 3) == 0);
      cyc_pending = 1'($urandom);
      cfg_we  = (($urandom % 5) == 0);
      cfg_dir = 3'($urandom); cfg_dat = 3'($urandom);
      tick();
    end
    cmp_all("R8 final");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule